// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped data cache with a small fully associative buffer that holds lines recently pushed out of the main array. A request is looked up in the main array first. Its data word is read out in the same cycle as the tag compare, so a hit completes with no wait.

When the main array misses, every entry of the victim buffer compares its stored block address against the request in parallel. On a buffer hit, the wanted line and the line currently at that index trade places. The request then completes one cycle later, with no memory access. When both structures miss, the block requests a full line from the next memory level and stalls the request until the fill arrives. The line that the fill displaces moves into the victim buffer.

The processor holds its request fields steady until it sees `req_ready`. The memory side takes a line-read request, returns one fill beat with the whole line, and accepts a write-back pulse whenever a valid line leaves the victim buffer.

Top module: `dmv_cache`

## Requirements
- R1: Address fields with default parameters: bits [4:0] select a byte in a 32-byte line, bits [9:5] are the index of one of 32 sets, and bits [31:10] are the tag. Bits [4:2] select the 32-bit word, and word w occupies line bits [32w+31:32w].
- R2: Reset invalidates every main-array line and every victim entry. After reset no request is acknowledged and no memory read is issued until a request arrives, and the first access to any address misses.
- R3: A read or write that hits the main array is acknowledged in the same cycle it is presented. In that cycle `req_ready`=1, `resp_hit`=1 and `resp_rdata` is the addressed word, and no memory read is issued.
- R4: A write acknowledged as a hit replaces the addressed word. Later reads return the new value, including after the line has moved through the victim buffer.
- R5: On a miss in both structures, `mem_rd_valid` is raised in the cycle the request is presented, with the line-aligned request address on `mem_rd_addr`. It stays high with `req_ready`=0 until the cycle `mem_fill_valid` is seen. The next cycle acknowledges the request with `resp_hit`=0.
- R6: A valid line displaced by a fill is placed in the victim buffer together with its full block address.
- R7: A victim hit is acknowledged in the cycle after the request is presented, with `resp_hit`=1 and no memory read. The displaced main line, if valid, takes over the victim entry that hit; if it is not valid, that entry becomes empty.
- R8: Fill insertions into the victim buffer go to entries 0,1,2,3 in rotation; a victim-hit swap does not move the rotation. When the target entry is valid, its line is written back in the fill cycle, with `mem_wb_valid`=1 and the entry's line address and data.
- R9: A fill into an index whose line is not valid inserts nothing into the victim buffer and leaves the rotation unchanged.
- R10: A block address is present in at most one place: the main array or one victim entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present; held until acknowledged |
| req_write | input | 1 | 1 = write the word, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data word |
| req_ready | output | 1 | Request completes this cycle |
| resp_hit | output | 1 | Request was served without a memory fetch (valid with req_ready) |
| resp_rdata | output | 32 | Addressed word (valid with req_ready) |
| mem_rd_valid | output | 1 | Line read request to memory |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_fill_valid | input | 1 | Fill line is present this cycle |
| mem_fill_data | input | 256 | Fill line data |
| mem_wb_valid | output | 1 | Line leaving the victim buffer is written back this cycle |
| mem_wb_addr | output | 32 | Line-aligned write-back address |
| mem_wb_data | output | 256 | Write-back line data |

## Verification
A wrong tag or valid bit shows up at the ports in the very next request to that index. It appears as a spurious hit with wrong data, or as a memory read where an acknowledge was due. A corrupted victim entry stays hidden until the block is requested again or the rotation reaches that entry. It then appears as a wrong swapped-in word, or as a write-back whose address or data is wrong. For that reason the bench compares acknowledge timing, data, and read and write-back traffic on every cycle against a behavioural model, with conflict-heavy traffic to a few sets.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } dmv_state_e;
endpackage

// File: rtl/dmv_victim_cam.sv
module dmv_victim_cam #(
    parameter int BLK_W   = 27,
    parameter int ENTRIES = 4,
    localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][BLK_W-1:0] ent_blk,
    input  logic [BLK_W-1:0]              key_blk,
    output logic [ENTRIES-1:0]            match_vec,
    output logic                          match_any,
    output logic [SEL_W-1:0]              match_sel
);
    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_valid[g] && (ent_blk[g] == key_blk);
    end

    always_comb begin
        match_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) match_sel = SEL_W'(i);
        end
    end

    assign match_any = |match_vec;
endmodule

// File: rtl/dmv_line_word.sv
module dmv_line_word #(
    parameter int LINE_W = 256,
    parameter int WORD_W = 32,
    localparam int WPL   = LINE_W / WORD_W,
    localparam int SEL_W = $clog2(WPL)
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [WORD_W-1:0] word_new,
    output logic [WORD_W-1:0] word_out,
    output logic [LINE_W-1:0] line_out
);
    logic [WPL-1:0][WORD_W-1:0] words;

    assign words    = line_in;
    assign word_out = words[word_sel];

    for (genvar g = 0; g < WPL; g++) begin : g_ins
        assign line_out[g*WORD_W +: WORD_W] =
            (word_sel == SEL_W'(g)) ? word_new : words[g];
    end
endmodule

// File: rtl/dmv_cache.sv
module dmv_cache #(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CACHE_BYTES = 1024,
    parameter int VICT_N      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [WORD_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic                       resp_hit,
    output logic [WORD_W-1:0]          resp_rdata,
    output logic                       mem_rd_valid,
    output logic [ADDR_W-1:0]          mem_rd_addr,
    input  logic                       mem_fill_valid,
    input  logic [LINE_BYTES*8-1:0]    mem_fill_data,
    output logic                       mem_wb_valid,
    output logic [ADDR_W-1:0]          mem_wb_addr,
    output logic [LINE_BYTES*8-1:0]    mem_wb_data
);
    import dmv_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SETS   = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(SETS);
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int TAG_W  = BLK_W - IDX_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WPL    = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WPL);
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int VP_W   = (VICT_N > 1) ? $clog2(VICT_N) : 1;

    typedef struct packed {
        dmv_state_e      st;
        logic [VP_W-1:0] ptr;
        logic            fetched;
    } ctl_t;

    ctl_t                          ctl_d, ctl_q;
    logic [SETS-1:0]               mval_d, mval_q;
    logic [SETS-1:0][TAG_W-1:0]    mtag_d, mtag_q;
    logic [LINE_W-1:0]             mdat_d [SETS];
    logic [LINE_W-1:0]             mdat_q [SETS];
    logic [VICT_N-1:0]             vval_d, vval_q;
    logic [VICT_N-1:0][BLK_W-1:0]  vblk_d, vblk_q;
    logic [LINE_W-1:0]             vdat_d [VICT_N];
    logic [LINE_W-1:0]             vdat_q [VICT_N];

    logic [IDX_W-1:0]  rq_idx;
    logic [TAG_W-1:0]  rq_tag;
    logic [BLK_W-1:0]  rq_blk;
    logic [WSEL_W-1:0] rq_wsel;
    logic [LINE_W-1:0] cur_line, upd_line;
    logic              main_hit;
    logic [VICT_N-1:0] v_match;
    logic              v_hit;
    logic [VP_W-1:0]   v_sel;
    logic [BSEL_W-1:0] unused_bytesel;

    assign rq_idx         = req_addr[OFF_W +: IDX_W];
    assign rq_tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign rq_blk         = req_addr[ADDR_W-1 : OFF_W];
    assign rq_wsel        = req_addr[BSEL_W +: WSEL_W];
    assign unused_bytesel = req_addr[BSEL_W-1:0];
    assign cur_line       = mdat_q[rq_idx];
    assign main_hit       = mval_q[rq_idx] && (mtag_q[rq_idx] == rq_tag);

    dmv_victim_cam #(.BLK_W(BLK_W), .ENTRIES(VICT_N)) u_cam (
        .ent_valid (vval_q),
        .ent_blk   (vblk_q),
        .key_blk   (rq_blk),
        .match_vec (v_match),
        .match_any (v_hit),
        .match_sel (v_sel)
    );

    dmv_line_word #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_word (
        .line_in  (cur_line),
        .word_sel (rq_wsel),
        .word_new (req_wdata),
        .word_out (resp_rdata),
        .line_out (upd_line)
    );

    assign mem_rd_addr = {rq_blk, {OFF_W{1'b0}}};
    assign mem_wb_addr = {vblk_q[ctl_q.ptr], {OFF_W{1'b0}}};
    assign mem_wb_data = vdat_q[ctl_q.ptr];

    always_comb begin
        ctl_d  = ctl_q;
        mval_d = mval_q;
        mtag_d = mtag_q;
        mdat_d = mdat_q;
        vval_d = vval_q;
        vblk_d = vblk_q;
        vdat_d = vdat_q;
        req_ready    = 1'b0;
        resp_hit     = 1'b0;
        mem_rd_valid = 1'b0;
        mem_wb_valid = 1'b0;
        case (ctl_q.st)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (main_hit) begin
                        req_ready     = 1'b1;
                        resp_hit      = !ctl_q.fetched;
                        ctl_d.fetched = 1'b0;
                        if (req_write) mdat_d[rq_idx] = upd_line;
                    end else if (v_hit) begin
                        // exchange the victim line with the resident one
                        mdat_d[rq_idx] = vdat_q[v_sel];
                        mtag_d[rq_idx] = vblk_q[v_sel][BLK_W-1 -: TAG_W];
                        mval_d[rq_idx] = 1'b1;
                        vdat_d[v_sel]  = cur_line;
                        vblk_d[v_sel]  = {mtag_q[rq_idx], rq_idx};
                        vval_d[v_sel]  = mval_q[rq_idx];
                    end else begin
                        mem_rd_valid = 1'b1;
                        ctl_d.st     = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_rd_valid = 1'b1;
                if (mem_fill_valid) begin
                    if (mval_q[rq_idx]) begin
                        mem_wb_valid      = vval_q[ctl_q.ptr];
                        vval_d[ctl_q.ptr] = 1'b1;
                        vblk_d[ctl_q.ptr] = {mtag_q[rq_idx], rq_idx};
                        vdat_d[ctl_q.ptr] = cur_line;
                        ctl_d.ptr = (ctl_q.ptr == VP_W'(VICT_N - 1)) ? '0 : ctl_q.ptr + 1'b1;
                    end
                    mdat_d[rq_idx] = mem_fill_data;
                    mtag_d[rq_idx] = rq_tag;
                    mval_d[rq_idx] = 1'b1;
                    ctl_d.st       = ST_LOOKUP;
                    ctl_d.fetched  = 1'b1;
                end
            end
            default: ctl_d.st = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '{st: ST_LOOKUP, ptr: '0, fetched: 1'b0};
            mval_q <= '0;
            mtag_q <= '0;
            vval_q <= '0;
            vblk_q <= '0;
            for (int i = 0; i < SETS; i++)   mdat_q[i] <= '0;
            for (int i = 0; i < VICT_N; i++) vdat_q[i] <= '0;
        end else begin
            ctl_q  <= ctl_d;
            mval_q <= mval_d;
            mtag_q <= mtag_d;
            mdat_q <= mdat_d;
            vval_q <= vval_d;
            vblk_q <= vblk_d;
            vdat_q <= vdat_d;
        end
    end

    AST_VICTIM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_match) && !(main_hit && v_hit)); // R10
    AST_STALL_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready); // R5
    AST_FILL_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_fill_valid && req_valid) |=> (!req_valid || (req_ready && !resp_hit))); // R5
    AST_SWAP_NEXT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !mem_rd_valid) |=> (!req_valid || (req_ready && resp_hit))); // R7
    AST_WB_ONLY_AT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb_valid |-> (mem_fill_valid && mem_rd_valid)); // R8
endmodule

// File: tb/dmv_cache_tb.sv
module dmv_cache_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         req_ready, resp_hit;
    logic [31:0]  resp_rdata;
    logic         mem_rd_valid;
    logic [31:0]  mem_rd_addr;
    logic         mem_fill_valid = 1'b0;
    logic [255:0] mem_fill_data = '0;
    logic         mem_wb_valid;
    logic [31:0]  mem_wb_addr;
    logic [255:0] mem_wb_data;

    always #2.5 clk = ~clk;

    dmv_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
    );

    int checks = 0, errors = 0, cyc = 0, wb_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // backing memory
    logic [255:0] backing [logic [31:0]];
    function automatic logic [255:0] line_of(input logic [31:0] la);
        logic [255:0] l;
        if (backing.exists(la)) return backing[la];
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = la ^ (32'h01010101 * w) ^ 32'hA5A50000;
        return l;
    endfunction

    // reference model state
    bit           mv [32];
    logic [21:0]  mt [32];
    logic [255:0] md [32];
    bit           vv [4];
    logic [26:0]  vb [4];
    logic [255:0] vd [4];
    int           vp;
    bit           fill_mode, fetched_flag;
    bit           pend_v, busy;
    int           cnt;
    logic [31:0]  rd_line;
    logic [255:0] pend_d;

    always @(posedge clk) begin
        #1;
        mem_fill_valid <= pend_v;
        mem_fill_data  <= pend_d;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
            for (int i = 0; i < 4; i++) begin vv[i] = 0; vb[i] = '0; vd[i] = '0; end
            vp = 0; fill_mode = 0; fetched_flag = 0; pend_v = 0; busy = 0; cnt = 0;
        end else begin
            bit e_rdy, e_hit, e_rd, e_wb;
            logic [31:0] e_rdata, e_wba;
            logic [255:0] e_wbd, tmp;
            logic [4:0] idx;
            logic [21:0] tg;
            logic [26:0] bk;
            int ws, found;
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
            e_rdy = 0; e_hit = 0; e_rd = 0; e_wb = 0; e_rdata = '0; e_wba = '0; e_wbd = '0;
            idx = req_addr[9:5]; tg = req_addr[31:10]; bk = req_addr[31:5]; ws = int'(req_addr[4:2]);
            if (!fill_mode) begin
                if (req_valid) begin
                    if (mv[idx] && mt[idx] == tg) begin
                        e_rdy = 1; e_hit = !fetched_flag; e_rdata = md[idx][ws*32 +: 32];
                        fetched_flag = 0;
                        if (req_write) md[idx][ws*32 +: 32] = req_wdata;
                    end else begin
                        found = -1;
                        for (int i = 0; i < 4; i++) if (vv[i] && vb[i] == bk) found = i;
                        if (found >= 0) begin
                            tmp = vd[found];
                            vd[found] = md[idx]; vb[found] = {mt[idx], idx}; vv[found] = mv[idx];
                            md[idx] = tmp; mt[idx] = tg; mv[idx] = 1;
                        end else begin
                            e_rd = 1; fill_mode = 1;
                        end
                    end
                end
            end else begin
                e_rd = 1;
                if (mem_fill_valid) begin
                    if (mv[idx]) begin
                        if (vv[vp]) begin e_wb = 1; e_wba = {vb[vp], 5'b0}; e_wbd = vd[vp]; end
                        vv[vp] = 1; vb[vp] = {mt[idx], idx}; vd[vp] = md[idx];
                        vp = (vp + 1) % 4;
                    end
                    md[idx] = mem_fill_data; mt[idx] = tg; mv[idx] = 1;
                    fill_mode = 0; fetched_flag = 1;
                end
            end
            // per-cycle comparison against the model
            chk(req_ready == e_rdy, "R3 R5 R7", "req_ready", 256'(req_ready), 256'(e_rdy));
            if (e_rdy) begin
                chk(resp_hit == e_hit, "R3 R5", "resp_hit", 256'(resp_hit), 256'(e_hit));
                chk(resp_rdata == e_rdata, "R1 R4 R10", "resp_rdata", 256'(resp_rdata), 256'(e_rdata));
            end
            chk(mem_rd_valid == e_rd, "R5 R7", "mem_rd_valid", 256'(mem_rd_valid), 256'(e_rd));
            if (e_rd) chk(mem_rd_addr == {bk, 5'b0}, "R5", "mem_rd_addr", 256'(mem_rd_addr), 256'({bk, 5'b0}));
            chk(mem_wb_valid == e_wb, "R8 R9", "mem_wb_valid", 256'(mem_wb_valid), 256'(e_wb));
            if (e_wb) begin
                chk(mem_wb_addr == e_wba, "R6 R8", "mem_wb_addr", 256'(mem_wb_addr), 256'(e_wba));
                chk(mem_wb_data == e_wbd, "R6 R8", "mem_wb_data", mem_wb_data, e_wbd);
            end
            if (mem_wb_valid) begin wb_seen++; backing[mem_wb_addr] = mem_wb_data; end
            // memory responder: fill three cycles after the read is seen
            if (pend_v) pend_v = 0;
            else if (mem_rd_valid && !busy) begin busy = 1; cnt = 3; rd_line = mem_rd_addr; end
            else if (busy) begin
                cnt--;
                if (cnt == 0) begin pend_v = 1; pend_d = line_of(rd_line); busy = 0; end
            end
        end
    end

    task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          output int cycles, output bit hit, output logic [31:0] rd);
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        cycles = 0;
        forever begin
            @(negedge clk); #1;
            cycles++;
            if (req_ready) begin hit = resp_hit; rd = resp_rdata; break; end
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        logic [31:0] la = {a[31:5], 5'b0};
        return la ^ (32'h01010101 * a[4:2]) ^ 32'hA5A50000;
    endfunction

    initial begin
        int c; bit h; logic [31:0] r; int wb0;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk(req_ready == 0 && mem_rd_valid == 0, "R2", "idle after reset",
            256'({req_ready, mem_rd_valid}), 256'(0));

        do_req(0, 32'h0000_0004, 0, c, h, r);
        chk(c == 6 && h == 0, "R2 R5", "cold miss cycles/hit", 256'({c, 31'(h)}), 256'({32'd6, 31'd0}));
        chk(r == pat(32'h4), "R1", "fill word1", 256'(r), 256'(pat(32'h4)));
        do_req(0, 32'h0000_001C, 0, c, h, r);
        chk(c == 1 && h == 1, "R3", "main hit same cycle", 256'(c), 256'(1));
        chk(r == pat(32'h1C), "R1", "word7 position", 256'(r), 256'(pat(32'h1C)));
        do_req(1, 32'h0000_0008, 32'hDEAD_BEEF, c, h, r);
        do_req(0, 32'h0000_0008, 0, c, h, r);
        chk(r == 32'hDEAD_BEEF, "R4", "write then read", 256'(r), 256'(32'hDEAD_BEEF));

        do_req(0, 32'h0000_0400, 0, c, h, r);
        chk(c == 6 && h == 0, "R5", "conflict miss", 256'(c), 256'(6));
        do_req(0, 32'h0000_0008, 0, c, h, r);
        chk(c == 2 && h == 1, "R6 R7", "victim hit one cycle later", 256'(c), 256'(2));
        chk(r == 32'hDEAD_BEEF, "R4 R7", "swapped-in written word", 256'(r), 256'(32'hDEAD_BEEF));
        do_req(0, 32'h0000_0404, 0, c, h, r);
        chk(c == 2 && h == 1, "R7", "swap back", 256'(c), 256'(2));

        // four more conflicting tags: the fourth insertion wraps and writes back
        wb0 = wb_seen;
        for (int t = 2; t <= 5; t++) do_req(0, 32'(t) << 10, 0, c, h, r);
        chk(wb_seen - wb0 == 1, "R8", "one write-back after wrap", 256'(wb_seen - wb0), 256'(1));
        do_req(0, 32'h0000_0008, 0, c, h, r);
        chk(c == 6 && r == 32'hDEAD_BEEF, "R8", "refetch of written-back line",
            256'(r), 256'(32'hDEAD_BEEF));

        wb0 = wb_seen;
        do_req(0, 32'h0000_0060, 0, c, h, r);
        chk(wb_seen == wb0 && c == 6, "R9", "fill into empty set, no insertion",
            256'(wb_seen - wb0), 256'(0));

        // conflict-heavy mixed traffic; R10 exclusivity is covered by data compares
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {19'd0, 3'(lfsr[2:0] % 6), 3'd0, 2'(lfsr[9:8]), 3'(lfsr[14:12]), 2'b00};
            do_req(lfsr[20:18] < 3'd2, a, lfsr ^ 32'h5A5A_0000, c, h, r);
        end
        @(posedge clk); #1 req_valid = 0;
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule